// File: doc/BRIEF.md
# Interrupt Level Gate and Vector Generator

This block decides, every clock, whether one pending event is taken. The event may be a level-independent trap, a non-maskable interrupt or a user interrupt request. For a taken event it reports the vector number and the handler vector address. User requests carry a 5-bit priority level, and they are weighed against a 5-bit current level mask held inside the block. Only the upper half of the level range (16 to 31) takes part in user arbitration.

The vector address is counted downward from the top of a 1 KB table. The table sits above a programmable table base. Vector numbers 0 and 1 are pinned to fixed addresses whatever the table base holds. Software can load the table base and the mask through two plain write ports. A mask write has a floor: once the mask is in the upper half, a write cannot take it below 16.

The accept strobe is a plain combinational control output. It is valid in the same cycle as the request that causes it. There is no valid/ready handshake and no back-pressure: a requester holds its request until it sees the strobe, and the downstream side must consume the strobe in that cycle.

Top module: `irq_level_gate`

## Requirements
- R1: After reset the mask reads 0 and the table base holds 0x000FFC00. With mask 0, no user request and no NMI is accepted.
- R2: A user request i (bit i of `irq_req`, level at `irq_lvl[5*i+4:5*i]`) is eligible only when its level is in 16..30 and is numerically below the mask. A level of 31 is never accepted, and a mask of 16 blocks every user request.
- R3: Among eligible user requests the lowest level wins, and a tie goes to the lowest index. The vector number is 16 + index.
- R4: The NMI has vector 15 and level 15. It is accepted when 15 is below the mask, and it takes precedence over all user requests.
- R5: The trap inputs are taken regardless of the mask and take precedence over the NMI. The lowest index wins. The vectors are: `trap_req[0]` 14, `trap_req[1]` 13, `trap_req[2]` 12, and `trap_req[3]` uses `swi_vec`. Taking a trap leaves the mask unchanged, and `acc_lvl` then reports the current mask.
- R6: `acc_stb` rises combinationally in the same cycle as the winning request, with at most one accept per cycle. On the following rising edge the mask loads `acc_lvl`.
- R7: A mask write (`mask_we`) loads `mask_wdata`, except when the mask is already 16 or more and the data is below 16, in which case it loads 16. The write is ignored in any cycle where `acc_stb` is high.
- R8: The vector address is (table base + 0x3FC − 4 × vector) with its two lowest bits forced to 00.
- R9: Vector 0 always yields address 0x000FFFFC and vector 1 always yields 0x000FFFF8, whatever the table base holds.
- R10: `tbr_we` loads `tbr_wdata` into the table base on the rising edge. Later accepts use the new base.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_req | input | NUM_IRQ | User interrupt requests |
| irq_lvl | input | 5*NUM_IRQ | Per-request level, request i at bits 5i+4..5i |
| nmi_req | input | 1 | Non-maskable interrupt request |
| trap_req | input | 4 | Level-independent trap requests |
| swi_vec | input | 8 | Vector number for the software trap on trap_req[3] |
| tbr_we | input | 1 | Table base write enable |
| tbr_wdata | input | 32 | Table base write data |
| mask_we | input | 1 | Mask write enable |
| mask_wdata | input | 5 | Mask write data |
| acc_stb | output | 1 | An event is accepted this cycle |
| acc_vec | output | 8 | Accepted vector number |
| acc_addr | output | 32 | Accepted vector address |
| acc_lvl | output | 5 | Level the mask takes on the next edge |
| mask_q | output | 5 | Current level mask |

## Verification
The accept strobe, vector number, address and reported level are combinational, so they are due in the same cycle the request is driven. The bench drives requests on the falling edge and samples these outputs 2 ns later, well before the next rising edge. Mask and table base changes land on the first rising edge after the stimulus and are read back on the following falling edge. A held request is checked one cycle on, to show that the raised mask has shut it out.

// File: rtl/irq_level_gate_pkg.sv
package irq_level_gate_pkg;
  localparam int LVL_W       = 5;
  localparam int VEC_W       = 8;
  localparam int ADDR_W      = 32;
  localparam int NUM_TRAP    = 4;
  localparam logic [LVL_W-1:0]  LVL_FLOOR = 5'd16;
  localparam logic [LVL_W-1:0]  LVL_OFF   = 5'd31;
  localparam logic [LVL_W-1:0]  NMI_LVL   = 5'd15;
  localparam logic [VEC_W-1:0]  NMI_VEC   = 8'd15;
  localparam logic [VEC_W-1:0]  USER_VEC0 = 8'd16;
  localparam logic [ADDR_W-1:0] TBR_RST   = 32'h000F_FC00;
  localparam logic [ADDR_W-1:0] TBL_TOP   = 32'h0000_03FC;
  localparam logic [ADDR_W-1:0] FIX_VEC0  = 32'h000F_FFFC;
  localparam logic [ADDR_W-1:0] FIX_VEC1  = 32'h000F_FFF8;

  typedef enum logic [1:0] {SRC_NONE, SRC_TRAP, SRC_NMI, SRC_USER} src_e;

  function automatic logic [LVL_W-1:0] floor_write(
    input logic [LVL_W-1:0] cur, input logic [LVL_W-1:0] wdata);
    if (cur >= LVL_FLOOR && wdata < LVL_FLOOR) return LVL_FLOOR;
    return wdata;
  endfunction

  function automatic logic [VEC_W-1:0] trap_vector(
    input int idx, input logic [VEC_W-1:0] swi);
    case (idx)
      0:       return 8'd14;
      1:       return 8'd13;
      2:       return 8'd12;
      default: return swi;
    endcase
  endfunction
endpackage

// File: rtl/ilg_user_arb.sv
module ilg_user_arb
  import irq_level_gate_pkg::*;
#(
  parameter int NUM_IRQ = 8,
  localparam int IDX_W = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1
) (
  input  logic [NUM_IRQ-1:0]       req,
  input  logic [NUM_IRQ*LVL_W-1:0] lvl,
  input  logic [LVL_W-1:0]         mask,
  output logic                     found,
  output logic [IDX_W-1:0]         idx,
  output logic [LVL_W-1:0]         best_lvl
);
  logic [NUM_IRQ-1:0] elig;

  generate
    for (genvar g = 0; g < NUM_IRQ; g++) begin : g_elig
      wire [LVL_W-1:0] l = lvl[g*LVL_W +: LVL_W];
      assign elig[g] = req[g] && (l >= LVL_FLOOR) && (l != LVL_OFF) && (l < mask);
    end
  endgenerate

  always_comb begin
    found    = 1'b0;
    idx      = '0;
    best_lvl = '1;
    for (int i = 0; i < NUM_IRQ; i++) begin
      if (elig[i] && (!found || lvl[i*LVL_W +: LVL_W] < best_lvl)) begin
        found    = 1'b1;
        idx      = IDX_W'(i);
        best_lvl = lvl[i*LVL_W +: LVL_W];
      end
    end
  end
endmodule

// File: rtl/ilg_trap_pick.sv
module ilg_trap_pick
  import irq_level_gate_pkg::*;
(
  input  logic [NUM_TRAP-1:0] trap_req,
  input  logic [VEC_W-1:0]    swi_vec,
  output logic                hit,
  output logic [VEC_W-1:0]    vec
);
  always_comb begin
    hit = 1'b0;
    vec = '0;
    for (int i = NUM_TRAP - 1; i >= 0; i--) begin
      if (trap_req[i]) begin
        hit = 1'b1;
        vec = trap_vector(i, swi_vec);
      end
    end
  end
endmodule

// File: rtl/ilg_vec_addr.sv
module ilg_vec_addr
  import irq_level_gate_pkg::*;
(
  input  logic [ADDR_W-1:0] tbr,
  input  logic [VEC_W-1:0]  vec,
  output logic [ADDR_W-1:0] addr
);
  logic [ADDR_W-1:0] sum;

  assign sum = tbr + TBL_TOP - {{(ADDR_W-VEC_W-2){1'b0}}, vec, 2'b00};

  always_comb begin
    if (vec == 8'd0)      addr = FIX_VEC0;
    else if (vec == 8'd1) addr = FIX_VEC1;
    else                  addr = sum & ~32'h3;
  end
endmodule

// File: rtl/irq_level_gate.sv
module irq_level_gate
  import irq_level_gate_pkg::*;
#(
  parameter int NUM_IRQ = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NUM_IRQ-1:0]       irq_req,
  input  logic [NUM_IRQ*LVL_W-1:0] irq_lvl,
  input  logic                     nmi_req,
  input  logic [NUM_TRAP-1:0]      trap_req,
  input  logic [VEC_W-1:0]         swi_vec,
  input  logic                     tbr_we,
  input  logic [ADDR_W-1:0]        tbr_wdata,
  input  logic                     mask_we,
  input  logic [LVL_W-1:0]         mask_wdata,
  output logic                     acc_stb,
  output logic [VEC_W-1:0]         acc_vec,
  output logic [ADDR_W-1:0]        acc_addr,
  output logic [LVL_W-1:0]         acc_lvl,
  output logic [LVL_W-1:0]         mask_q
);
  localparam int IDX_W = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1;

  logic [LVL_W-1:0]  mask_r;
  logic [ADDR_W-1:0] tbr_r;
  logic              usr_found, trap_hit, nmi_ok;
  logic [IDX_W-1:0]  usr_idx;
  logic [LVL_W-1:0]  usr_lvl;
  logic [VEC_W-1:0]  trap_vec;
  src_e              src;

  ilg_user_arb #(.NUM_IRQ(NUM_IRQ)) u_arb (
    .req(irq_req), .lvl(irq_lvl), .mask(mask_r),
    .found(usr_found), .idx(usr_idx), .best_lvl(usr_lvl)
  );

  ilg_trap_pick u_trap (
    .trap_req(trap_req), .swi_vec(swi_vec), .hit(trap_hit), .vec(trap_vec)
  );

  assign nmi_ok = nmi_req && (NMI_LVL < mask_r);

  always_comb begin
    if (trap_hit)       src = SRC_TRAP;
    else if (nmi_ok)    src = SRC_NMI;
    else if (usr_found) src = SRC_USER;
    else                src = SRC_NONE;
  end

  always_comb begin
    acc_vec = '0;
    acc_lvl = mask_r;
    case (src)
      SRC_TRAP: acc_vec = trap_vec;
      SRC_NMI:  begin acc_vec = NMI_VEC; acc_lvl = NMI_LVL; end
      SRC_USER: begin acc_vec = USER_VEC0 + VEC_W'(usr_idx); acc_lvl = usr_lvl; end
      default:  ;
    endcase
  end

  assign acc_stb = (src != SRC_NONE);

  ilg_vec_addr u_addr (.tbr(tbr_r), .vec(acc_vec), .addr(acc_addr));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_r <= '0;
      tbr_r  <= TBR_RST;
    end else begin
      if (tbr_we) tbr_r <= tbr_wdata;
      if (acc_stb)      mask_r <= acc_lvl;
      else if (mask_we) mask_r <= floor_write(mask_r, mask_wdata);
    end
  end

  assign mask_q = mask_r;
endmodule

// File: rtl/irq_level_gate_chk.sv
module irq_level_gate_chk
  import irq_level_gate_pkg::*;
(
  input logic                clk,
  input logic                rst_n,
  input logic [NUM_TRAP-1:0] trap_req,
  input logic                acc_stb,
  input logic [VEC_W-1:0]    acc_vec,
  input logic [ADDR_W-1:0]   acc_addr,
  input logic [LVL_W-1:0]    acc_lvl,
  input logic [LVL_W-1:0]    mask_q
);
  assert_addr_align_R8: assert property (@(posedge clk) disable iff (!rst_n)
    acc_stb |-> acc_addr[1:0] == 2'b00);

  assert_fixed_vec0_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_stb && acc_vec == 8'd0) |-> acc_addr == FIX_VEC0);

  assert_fixed_vec1_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_stb && acc_vec == 8'd1) |-> acc_addr == FIX_VEC1);

  assert_mask_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
    acc_stb |=> mask_q == $past(acc_lvl));

  assert_mask_floor_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q >= LVL_FLOOR && !acc_stb) |=> mask_q >= LVL_FLOOR);

  assert_trap_first_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (|trap_req) |-> (acc_stb && acc_lvl == mask_q));

  assert_user_gate_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_stb && trap_req == '0 && acc_vec != NMI_VEC) |->
      (acc_lvl >= LVL_FLOOR && acc_lvl != LVL_OFF && acc_lvl < mask_q));
endmodule

bind irq_level_gate irq_level_gate_chk u_chk (
  .clk(clk), .rst_n(rst_n), .trap_req(trap_req), .acc_stb(acc_stb),
  .acc_vec(acc_vec), .acc_addr(acc_addr), .acc_lvl(acc_lvl), .mask_q(mask_q)
);

// File: tb/irq_level_gate_bench.sv
module irq_level_gate_bench;
  localparam int N = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] irq_req = '0;
  logic [N*5-1:0] irq_lvl = '0;
  logic         nmi_req = 1'b0;
  logic [3:0]   trap_req = '0;
  logic [7:0]   swi_vec = '0;
  logic         tbr_we = 1'b0;
  logic [31:0]  tbr_wdata = '0;
  logic         mask_we = 1'b0;
  logic [4:0]   mask_wdata = '0;
  logic         acc_stb;
  logic [7:0]   acc_vec;
  logic [31:0]  acc_addr;
  logic [4:0]   acc_lvl;
  logic [4:0]   mask_q;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  irq_level_gate #(.NUM_IRQ(N)) u_irq_level_gate (
    .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .irq_lvl(irq_lvl),
    .nmi_req(nmi_req), .trap_req(trap_req), .swi_vec(swi_vec),
    .tbr_we(tbr_we), .tbr_wdata(tbr_wdata), .mask_we(mask_we),
    .mask_wdata(mask_wdata), .acc_stb(acc_stb), .acc_vec(acc_vec),
    .acc_addr(acc_addr), .acc_lvl(acc_lvl), .mask_q(mask_q)
  );

  always #5 clk = ~clk;

  typedef struct packed {
    logic [4:0]   mask;
    logic [7:0]   req;
    logic [39:0]  lvls;
    logic         nmi;
    logic [3:0]   trap;
    logic [7:0]   swi;
    logic         stb;
    logic [7:0]   vec;
    logic [4:0]   nmask;
  } ent_t;

  localparam int NE = 12;
  // levels listed request 7 first, request 0 last
  localparam ent_t TBL [NE] = '{
    '{5'd31, 8'h01, {8{5'd20}}, 1'b0, 4'h0, 8'h00, 1'b1, 8'd16, 5'd20}, // R3 single
    '{5'd31, 8'hA0, {5'd18,5'd20,5'd25,5'd20,5'd20,5'd20,5'd20,5'd20},
      1'b0, 4'h0, 8'h00, 1'b1, 8'd23, 5'd18},                            // R3 lowest level
    '{5'd31, 8'h0C, {8{5'd22}}, 1'b0, 4'h0, 8'h00, 1'b1, 8'd18, 5'd22}, // R3 tie
    '{5'd20, 8'h02, {8{5'd20}}, 1'b0, 4'h0, 8'h00, 1'b0, 8'd0,  5'd20}, // R2 equal
    '{5'd31, 8'h01, {8{5'd31}}, 1'b0, 4'h0, 8'h00, 1'b0, 8'd0,  5'd31}, // R2 level 31
    '{5'd31, 8'h10, {8{5'd10}}, 1'b0, 4'h0, 8'h00, 1'b0, 8'd0,  5'd31}, // R2 low half
    '{5'd16, 8'hFF, {8{5'd17}}, 1'b0, 4'h0, 8'h00, 1'b0, 8'd0,  5'd16}, // R2 mask 16
    '{5'd31, 8'h01, {8{5'd20}}, 1'b1, 4'h0, 8'h00, 1'b1, 8'd15, 5'd15}, // R4 over user
    '{5'd10, 8'h00, {8{5'd20}}, 1'b1, 4'h0, 8'h00, 1'b0, 8'd0,  5'd10}, // R4 masked
    '{5'd0,  8'h00, {8{5'd20}}, 1'b1, 4'h1, 8'h00, 1'b1, 8'd14, 5'd0},  // R5 over NMI
    '{5'd20, 8'h00, {8{5'd20}}, 1'b0, 4'hA, 8'h40, 1'b1, 8'd13, 5'd20}, // R5 index order
    '{5'd25, 8'h00, {8{5'd20}}, 1'b0, 4'h8, 8'h40, 1'b1, 8'd64, 5'd25}  // R5 software
  };

  function automatic logic [31:0] exp_addr(input logic [31:0] tbr, input logic [7:0] v);
    if (v == 0) return 32'h000FFFFC;
    if (v == 1) return 32'h000FFFF8;
    return (tbr + 32'h3FC - 32'(v) * 4) & ~32'h3;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic clear_in();
    irq_req = '0; nmi_req = 1'b0; trap_req = '0; swi_vec = '0;
    tbr_we = 1'b0; mask_we = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    clear_in();
    rst_n = 1'b0;
    step();
    step();
    rst_n = 1'b1;
  endtask

  task automatic write_mask(input logic [4:0] v);
    mask_we = 1'b1; mask_wdata = v;
    step();
    mask_we = 1'b0;
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    // R1 reset state
    do_reset();
    chk("R1 mask after reset", 32'(mask_q), 32'd0);
    chk("R1 no strobe idle", 32'(acc_stb), 32'd0);
    irq_req = '1; irq_lvl = {8{5'd20}}; nmi_req = 1'b1;
    #2 chk("R1 mask 0 blocks user and NMI", 32'(acc_stb), 32'd0);
    clear_in();
    trap_req = 4'h1;
    #2 chk("R1 R5 trap vector", 32'(acc_vec), 32'd14);
    chk("R1 reset table base address", acc_addr, 32'h000FFFC4);
    step();
    clear_in();
    chk("R5 trap leaves mask", 32'(mask_q), 32'd0);

    // table walk: R2 R3 R4 R5 patterns
    for (int e = 0; e < NE; e++) begin
      do_reset();
      write_mask(TBL[e].mask);
      irq_req = TBL[e].req; irq_lvl = TBL[e].lvls; nmi_req = TBL[e].nmi;
      trap_req = TBL[e].trap; swi_vec = TBL[e].swi;
      #2;
      chk($sformatf("R2/R3/R4/R5 entry %0d strobe", e), 32'(acc_stb), 32'(TBL[e].stb));
      if (TBL[e].stb) begin
        chk($sformatf("R3/R4/R5 entry %0d vector", e), 32'(acc_vec), 32'(TBL[e].vec));
        chk($sformatf("R8 entry %0d address", e), acc_addr, exp_addr(32'h000FFC00, TBL[e].vec));
      end
      step();
      clear_in();
      chk($sformatf("R6 entry %0d mask after", e), 32'(mask_q), 32'(TBL[e].nmask));
    end

    // R10 R9: table base write, fixed vectors
    tbr_we = 1'b1; tbr_wdata = 32'h0001_0000;
    step();
    tbr_we = 1'b0;
    trap_req = 4'h8; swi_vec = 8'd0;
    #2 chk("R9 vector 0 fixed", acc_addr, 32'h000FFFFC);
    swi_vec = 8'd1;
    #2 chk("R9 vector 1 fixed", acc_addr, 32'h000FFFF8);
    swi_vec = 8'd2;
    #2 chk("R10 new base used", acc_addr, 32'h000103F4);
    step();
    clear_in();

    // R8 low bits forced
    tbr_we = 1'b1; tbr_wdata = 32'h0002_0003;
    step();
    tbr_we = 1'b0;
    trap_req = 4'h8; swi_vec = 8'd3;
    #2 chk("R8 low bits cleared", acc_addr, 32'h000203F0);
    step();
    clear_in();

    // R7 write floor
    do_reset();
    write_mask(5'd20);
    chk("R7 plain write", 32'(mask_q), 32'd20);
    write_mask(5'd5);
    chk("R7 clamp to 16", 32'(mask_q), 32'd16);
    write_mask(5'd25);
    chk("R7 upper write", 32'(mask_q), 32'd25);
    do_reset();
    write_mask(5'd3);
    chk("R7 low write from 0", 32'(mask_q), 32'd3);

    // R7 write ignored during accept
    do_reset();
    write_mask(5'd31);
    irq_req = 8'h01; irq_lvl = {8{5'd20}}; mask_we = 1'b1; mask_wdata = 5'd5;
    #2 chk("R6 strobe same cycle", 32'(acc_stb), 32'd1);
    step();
    clear_in();
    chk("R7 write lost to accept", 32'(mask_q), 32'd20);

    // R5 trap with write: mask unchanged
    trap_req = 4'h4; mask_we = 1'b1; mask_wdata = 5'd28;
    #2 chk("R5 cop error vector", 32'(acc_vec), 32'd12);
    step();
    clear_in();
    chk("R5 mask held on trap", 32'(mask_q), 32'd20);

    // R6 held request shut out after mask raise
    irq_req = 8'h02; irq_lvl = {8{5'd18}};
    #2 chk("R6 held first cycle", 32'(acc_stb), 32'd1);
    step();
    chk("R6 mask took level", 32'(mask_q), 32'd18);
    #2 chk("R6 held request blocked", 32'(acc_stb), 32'd0);
    clear_in();

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule